// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block links the companded-sample side of a voice codec to a strobed serial line. The line carries a bit clock and an active-high strobe that marks one 8-bit timeslot in each 8 kHz frame. The same timeslot is used in both directions. While the strobe is high, the port shifts one transmit byte out, most significant bit first. It updates the line data on rising bit-clock edges and samples the incoming line on falling bit-clock edges. No frame of latency is added, so the byte received in a slot is delivered in that same slot.

Everything runs on one system clock, which must be several times faster than the bit clock. The bit clock, strobe and serial input pass through a synchroniser of `SYNC_STAGES` flops. Edges are found from the synchronised copies. Transmit bytes arrive on a valid/ready stream that holds one byte. `tx_ready` is high while the holding register is empty. A byte offered while `tx_ready` is low is not taken, and the producer keeps `tx_valid` and `tx_data` steady until it is. The receive stream has no back-pressure: `rx_valid` is a single-cycle pulse, and the consumer must take `rx_data` in that cycle. Two mute inputs and a law select are plain static control pins. The serial output is shown as a data bit plus an output enable; when the enable is low the line is high-impedance.

Top module: `pcm_strobe_port`

## Requirements
- R1: `dout_oe` is high only while the synchronised strobe is high, and `dout` is 0 whenever `dout_oe` is 0.
- R2: The transmit byte goes out MSB first. Its first bit is on `dout` when `dout_oe` rises, and each later bit replaces the previous one on the next bit-clock rising edge after a falling edge inside the slot.
- R3: `din` is sampled on falling bit-clock edges inside the slot, MSB first. After the eighth sample, `rx_valid` pulses for exactly one cycle with the assembled byte, within the same slot.
- R4: When `tx_mute` is 1 at the start of a slot, that slot sends the quiet code. A held transmit byte is still used up, so `tx_ready` returns to 1.
- R5: When `rx_mute` is 1 at the eighth sample, `rx_data` carries the quiet code in place of the sampled byte.
- R6: The quiet code is negative zero and depends on `law_a`: 8'h55 (0101_0101) when `law_a` is 1 (A-law), and 8'h7F (0111_1111) when `law_a` is 0 (mu-law).
- R7: If the strobe drops before eight samples, the partial byte is discarded, no `rx_valid` pulse is produced, and the next slot starts again at bit 0.
- R8: The byte to transmit is taken from the holding register at the strobe's rising edge. Stream activity during the slot does not change the bits being sent.
- R9: The holding register stores one byte. `tx_ready` goes low once a byte is accepted, and a byte offered while it is low is not accepted. If the register is empty at the start of a slot, the quiet code is sent.
- R10: While `rst_n` is low and after it is released, `dout_oe`, `dout` and `rx_valid` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset that clears all state |
| bclk | input | 1 | Serial bit clock, asynchronous to `clk` |
| stb | input | 1 | Active-high timeslot strobe |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for `dout` (0 means high-impedance) |
| tx_data | input | 8 | Transmit byte offered on the stream |
| tx_valid | input | 1 | Transmit byte is valid |
| tx_ready | output | 1 | Holding register can accept a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Single-cycle pulse: `rx_data` is valid |
| tx_mute | input | 1 | Send the quiet code on the line |
| rx_mute | input | 1 | Deliver the quiet code in place of line data |
| law_a | input | 1 | 1 selects A-law, 0 selects mu-law |

## Verification
The bench uses the default `SYNC_STAGES` of 2 and runs the bit clock at 16 system clocks per bit. That leaves a half bit period of 8 cycles, more than the synchroniser and register delay. Line bits can therefore be checked just before each falling edge, and inputs can be driven just after each rising edge, without counting exact cycles. It also leaves room inside a single slot to push a new stream byte, to offer a byte that must be refused, and to cut a slot short after three bits.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int WORD_W = 8;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  // negative-zero code for the selected companding law
  function automatic logic [WORD_W-1:0] quiet_code(input logic law_a);
    return law_a ? 8'h55 : 8'h7F;
  endfunction
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              slot_start,
  input  logic              slot_on,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              mute,
  input  logic              law_a,
  output logic              dout,
  output logic              dout_oe
);
  logic              hold_full;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] shreg;
  logic              advance;
  logic              oe_q;

  assign tx_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      shreg     <= '0;
      advance   <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      if (tx_valid && !hold_full) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end
      if (slot_start) begin
        if (mute || !hold_full) shreg <= quiet_code(law_a);
        else                    shreg <= hold_q;
        if (hold_full) hold_full <= 1'b0;
        advance <= 1'b0;
      end else if (slot_on) begin
        if (bit_fall) advance <= 1'b1;
        else if (bit_rise && advance) begin
          shreg   <= {shreg[WORD_W-2:0], 1'b0};
          advance <= 1'b0;
        end
      end
      oe_q <= slot_on;
    end
  end

  assign dout_oe = oe_q;
  assign dout    = oe_q & shreg[WORD_W-1];
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_on,
  input  logic              bit_fall,
  input  logic              din,
  input  logic              mute,
  input  logic              law_a,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_byte;

  assign next_byte = {shreg[WORD_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!slot_on) begin
        cnt <= '0;
      end else if (bit_fall && cnt < FULL) begin
        shreg <= next_byte;
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          rx_valid <= 1'b1;
          rx_data  <= mute ? quiet_code(law_a) : next_byte;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              stb,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              tx_mute,
  input  logic              rx_mute,
  input  logic              law_a
);
  logic [2:0] line_s;
  logic [1:0] prev_q;
  logic       bclk_s, stb_s, din_s;
  logic       bit_rise, bit_fall, slot_start;

  pcm_in_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({din, stb, bclk}), .q(line_s)
  );

  assign bclk_s = line_s[0];
  assign stb_s  = line_s[1];
  assign din_s  = line_s[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= {stb_s, bclk_s};

  assign bit_rise   = bclk_s & ~prev_q[0];
  assign bit_fall   = ~bclk_s & prev_q[0];
  assign slot_start = stb_s & ~prev_q[1];

  pcm_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .slot_start(slot_start), .slot_on(stb_s),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .mute(tx_mute),
    .law_a(law_a), .dout(dout), .dout_oe(dout_oe)
  );

  pcm_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .slot_on(stb_s), .bit_fall(bit_fall),
    .din(din_s), .mute(rx_mute), .law_a(law_a),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/pcm_strobe_port_chk.sv
module pcm_strobe_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dout,
  input logic       dout_oe,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_mute,
  input logic       law_a,
  input logic       tx_valid,
  input logic       tx_ready
);
  // R1: line carries no data while the output is released
  a_r1_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);

  // R3: a received byte is flagged for a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5, R6: muted receive byte is the law's negative zero
  a_r5_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && $past(rx_mute) |-> rx_data == ($past(law_a) ? 8'h55 : 8'h7F));

  // R9: an accepted byte fills the single holding entry
  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
endmodule

bind pcm_strobe_port pcm_strobe_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dout(dout), .dout_oe(dout_oe),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_mute(rx_mute),
  .law_a(law_a), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/sim_pcm_strobe_port.sv
`timescale 1ns/1ps
module sim_pcm_strobe_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0;
  logic       stb = 1'b0;
  logic       din = 1'b0;
  logic       dout, dout_oe;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       tx_mute = 1'b0;
  logic       rx_mute = 1'b0;
  logic       law_a = 1'b0;

  int tests = 0;
  int fails = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = '0;
  logic [7:0] tx_obs;
  bit   done = 0;

  pcm_strobe_port #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .stb(stb), .din(din),
    .dout(dout), .dout_oe(dout_oe), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_mute(tx_mute), .rx_mute(rx_mute), .law_a(law_a)
  );

  always #2.5 clk = ~clk;

  // bit clock: 16 system clocks per bit
  int bdiv = 0;
  always @(negedge clk) begin
    if (bdiv == 7) begin bdiv <= 0; bclk <= ~bclk; end
    else bdiv <= bdiv + 1;
  end

  always @(negedge clk)
    if (rst_n && rx_valid) begin rx_cnt++; rx_last = rx_data; end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // one timeslot of nbits; records the line byte into tx_obs
  task automatic run_slot(input logic [7:0] din_b, input int nbits);
    tx_obs = '0;
    @(posedge bclk); #1;
    stb = 1'b1; din = din_b[7];
    for (int k = 0; k < nbits; k++) begin
      @(negedge bclk); #1;
      tx_obs[7-k] = dout_oe ? dout : 1'bx;
      @(posedge bclk); #1;
      if (k < 7) din = din_b[6-k];
    end
    stb = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 oe", {7'd0, dout_oe}, 8'd0);
    check("R10 dout", {7'd0, dout}, 8'd0);
    check("R10 rx_valid", {7'd0, rx_valid}, 8'd0);
    check("R10 tx_ready", {7'd0, tx_ready}, 8'd1);
  endtask

  task automatic t_basic(input logic [7:0] tb_tx, input logic [7:0] tb_rx);
    int c0;
    push(tb_tx);
    c0 = rx_cnt;
    run_slot(tb_rx, 8);
    check("R2 tx byte", tx_obs, tb_tx);
    check("R3 rx count", 8'(rx_cnt - c0), 8'd1);
    check("R3 rx byte", rx_last, tb_rx);
    check("R1 oe low after slot", {7'd0, dout_oe}, 8'd0);
  endtask

  task automatic t_tx_mute(input logic law);
    law_a = law; tx_mute = 1'b1;
    push(8'h96);
    run_slot(8'h00, 8);
    check("R4 R6 tx quiet", tx_obs, law ? 8'h55 : 8'h7F);
    check("R4 byte consumed", {7'd0, tx_ready}, 8'd1);
    tx_mute = 1'b0; law_a = 1'b0;
  endtask

  task automatic t_rx_mute(input logic law);
    law_a = law; rx_mute = 1'b1;
    push(8'h3D);
    run_slot(8'hE1, 8);
    check("R5 R6 rx quiet", rx_last, law ? 8'h55 : 8'h7F);
    check("R5 tx unaffected", tx_obs, 8'h3D);
    rx_mute = 1'b0; law_a = 1'b0;
  endtask

  task automatic t_underrun;
    law_a = 1'b1;
    run_slot(8'h00, 8);
    check("R9 underrun quiet", tx_obs, 8'h55);
    law_a = 1'b0;
  endtask

  task automatic t_short;
    int c0;
    push(8'hC3);
    c0 = rx_cnt;
    run_slot(8'hFF, 3);
    check("R7 no pulse", 8'(rx_cnt - c0), 8'd0);
    push(8'h5A);
    c0 = rx_cnt;
    run_slot(8'hE7, 8);
    check("R7 restart rx", rx_last, 8'hE7);
    check("R7 restart count", 8'(rx_cnt - c0), 8'd1);
    check("R7 restart tx", tx_obs, 8'h5A);
  endtask

  task automatic t_midslot;
    push(8'h11);
    fork
      run_slot(8'h00, 8);
      begin
        repeat (40) @(negedge clk);
        push(8'h22);
        check("R9 ready low", {7'd0, tx_ready}, 8'd0);
        tx_data = 8'h33; tx_valid = 1'b1;
        repeat (4) @(negedge clk);
        tx_valid = 1'b0;
      end
    join
    check("R8 latched byte", tx_obs, 8'h11);
    run_slot(8'h00, 8);
    check("R9 refused byte", tx_obs, 8'h22);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic(8'hA5, 8'h3C);
    t_basic(8'h01, 8'h80);
    t_tx_mute(1'b0);
    t_tx_mute(1'b1);
    t_rx_mute(1'b1);
    t_rx_mute(1'b0);
    t_underrun;
    t_short;
    t_midslot;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule